// File: doc/BRIEF.md
# Packed Lane Add/Subtract Unit

This block is the add/subtract slice of a 32-bit packed-integer execution pipe. Each operation works on four 8-bit lanes or two 16-bit lanes at once. The opcode does not name the lane width or the signedness. Both come from the register bank that holds the destination and the two sources. One range of register numbers holds signed bytes, the next holds unsigned bytes, the next signed halfwords, and the last unsigned halfwords.

A two-bit operation select picks add or subtract, and plain or halving arithmetic. A two-bit mode field then changes how the result is used. Mode 00 is plain modular arithmetic. Mode 01 forces saturation for this instruction only. Modes 10 and 11 merge the result lane by lane with the old destination word, under a predicate word or under its bitwise inverse.

The issue stage supplies the operand words, the old destination word and the predicate word. The unit returns a registered result one clock later, along with a flag that reports a register combination outside the banks.

Top module: `lane_addsub_unit`

## Requirements
- R1: When all three indices fall in 2..7, the unit uses four signed 8-bit lanes. When all three fall in 8..15, it uses four unsigned 8-bit lanes. Lane i occupies bits [8i+7:8i].
- R2: When all three indices fall in 16..23, the unit uses two signed 16-bit lanes. When all three fall in 24..29, it uses two unsigned 16-bit lanes. Lane i occupies bits [16i+15:16i].
- R3: The unit sets `outIllegal` and drives `outResult` to zero in two cases: the three indices do not all share one bank, or any index is 0, 1, 30 or 31.
- R4: `opSel` bit 0 selects subtract (1) or add (0). With `opSel` bit 1 at 0 and mode 00, every lane holds the sum or difference modulo 2^lane-width.
- R5: With mode 01 and `opSel` bit 1 at 0, every lane clamps to its type's range. The signed range is [-2^(n-1), 2^(n-1)-1] and the unsigned range is [0, 2^n-1].
- R6: With `opSel` bit 1 at 1, every lane holds floor((a±b)/2). The sum or difference is formed one bit wider than the lane. The shift is arithmetic for signed banks and logical for unsigned banks, so an unsigned difference that goes negative wraps. Mode 01 does not change a halving result.
- R7: In mode 10, lane i takes the computed value when bit i of `predWord` is 1. Otherwise it keeps lane i of `oldDest`. Bits of `predWord` above the lane count have no effect.
- R8: In mode 11, lane i takes the computed value when bit i of `predWord` is 0. Otherwise it keeps lane i of `oldDest`.
- R9: `outValid`, `outResult` and `outIllegal` reflect the inputs sampled at the clock edge where `inValid` was 1, and they appear one edge later. `outValid` is 0 after any edge where `inValid` was 0. A synchronous reset clears `outValid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operation strobe |
| rdIdx | input | 5 | Destination register index |
| rs1Idx | input | 5 | First source register index |
| rs2Idx | input | 5 | Second source register index |
| opSel | input | 2 | bit0 subtract, bit1 halving |
| mode | input | 2 | 00 plain, 01 saturate, 10 mask, 11 inverted mask |
| srcA | input | 32 | First operand word |
| srcB | input | 32 | Second operand word |
| oldDest | input | 32 | Current destination word |
| predWord | input | 32 | Predicate mask word |
| outValid | output | 1 | Result valid |
| outResult | output | 32 | Result word |
| outIllegal | output | 1 | Register combination rejected |

## Verification
The bench builds the unit with its default parameters: a 32-bit word, 5-bit indices and the standard bank bounds. In that configuration each lane type has small enough operands that a sweep over a set of sixteen edge values can pair every value with every other. This reaches both clamp limits, every carry and borrow, and the wrap of negative halving differences, for all four banks and all op and mode combinations. The sweep places the indices at both ends of each bank, and a separate set of index triples probes the reserved and cross-bank cases.

// File: rtl/lane_addsub_pkg.sv
package lane_addsub_pkg;

  typedef enum logic [2:0] {
    BANK_NONE = 3'd0,
    BANK_S8   = 3'd1,
    BANK_U8   = 3'd2,
    BANK_S16  = 3'd3,
    BANK_U16  = 3'd4
  } bank_e;

  // Strobes from decode to the arithmetic datapath
  typedef struct packed {
    logic wide;      // 16-bit lanes
    logic sgn;       // signed bank
    logic sub;       // subtract
    logic halve;     // halving variant
    logic sat;       // forced saturation
    logic useMask;   // merge under predicate
    logic invMask;   // predicate inverted
    logic illegal;   // reject, drive zero
  } ctrl_t;

endpackage

// File: rtl/addsub_ctrl.sv
module addsub_ctrl
  import lane_addsub_pkg::*;
#(
  parameter int IDX_W  = 5,
  parameter int S8_LO  = 2,
  parameter int S8_HI  = 7,
  parameter int U8_LO  = 8,
  parameter int U8_HI  = 15,
  parameter int S16_LO = 16,
  parameter int S16_HI = 23,
  parameter int U16_LO = 24,
  parameter int U16_HI = 29
) (
  input  logic [IDX_W-1:0] rdIdx,
  input  logic [IDX_W-1:0] rs1Idx,
  input  logic [IDX_W-1:0] rs2Idx,
  input  logic [1:0]       opSel,
  input  logic [1:0]       mode,
  output ctrl_t            ctrl
);

  function automatic bank_e bankOf(input logic [IDX_W-1:0] idx);
    int unsigned v;
    v = int'(idx);
    if (v >= S8_LO && v <= S8_HI)        return BANK_S8;
    else if (v >= U8_LO && v <= U8_HI)   return BANK_U8;
    else if (v >= S16_LO && v <= S16_HI) return BANK_S16;
    else if (v >= U16_LO && v <= U16_HI) return BANK_U16;
    else                                 return BANK_NONE;
  endfunction

  bank_e bankD, bankA, bankB;

  always_comb begin
    bankD = bankOf(rdIdx);
    bankA = bankOf(rs1Idx);
    bankB = bankOf(rs2Idx);
    ctrl.illegal = (bankD == BANK_NONE) || (bankA != bankD) || (bankB != bankD);
    ctrl.wide    = (bankD == BANK_S16) || (bankD == BANK_U16);
    ctrl.sgn     = (bankD == BANK_S8) || (bankD == BANK_S16);
    ctrl.sub     = opSel[0];
    ctrl.halve   = opSel[1];
    ctrl.sat     = (mode == 2'b01) && !opSel[1];
    ctrl.useMask = mode[1];
    ctrl.invMask = mode[1] & mode[0];
  end

endmodule

// File: rtl/addsub_lane.sv
module addsub_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] old,
  input  logic         sgn,
  input  logic         sub,
  input  logic         halve,
  input  logic         sat,
  input  logic         en,
  output logic [W-1:0] res
);

  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] UMAX = {W{1'b1}};

  logic [W:0]   ax, bx, sum;
  logic [W-1:0] arith;

  always_comb begin
    ax  = {sgn & a[W-1], a};
    bx  = {sgn & b[W-1], b};
    sum = sub ? (ax - bx) : (ax + bx);
    if (halve) begin
      arith = sum[W:1];
    end else if (sat && sgn && (sum[W] != sum[W-1])) begin
      arith = sum[W] ? SMIN : SMAX;
    end else if (sat && !sgn && sum[W]) begin
      arith = sub ? '0 : UMAX;
    end else begin
      arith = sum[W-1:0];
    end
    res = en ? arith : old;
  end

endmodule

// File: rtl/addsub_datapath.sv
module addsub_datapath
  import lane_addsub_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  ctrl_t             ctrl,
  input  logic [WORD_W-1:0] srcA,
  input  logic [WORD_W-1:0] srcB,
  input  logic [WORD_W-1:0] oldDest,
  input  logic [WORD_W-1:0] predWord,
  output logic              outValid,
  output logic [WORD_W-1:0] outResult,
  output logic              outIllegal
);

  localparam int NARROW_N = WORD_W / 8;
  localparam int WIDE_N   = WORD_W / 16;

  logic [WORD_W-1:0] maskWord, narrowRes, wideRes, nextRes;

  assign maskWord = ctrl.invMask ? ~predWord : predWord;

  for (genvar i = 0; i < NARROW_N; i++) begin : gNarrow
    addsub_lane #(.W(8)) uLane (
      .a(srcA[8*i +: 8]), .b(srcB[8*i +: 8]), .old(oldDest[8*i +: 8]),
      .sgn(ctrl.sgn), .sub(ctrl.sub), .halve(ctrl.halve), .sat(ctrl.sat),
      .en(!ctrl.useMask || maskWord[i]),
      .res(narrowRes[8*i +: 8])
    );
  end

  for (genvar i = 0; i < WIDE_N; i++) begin : gWide
    addsub_lane #(.W(16)) uLane (
      .a(srcA[16*i +: 16]), .b(srcB[16*i +: 16]), .old(oldDest[16*i +: 16]),
      .sgn(ctrl.sgn), .sub(ctrl.sub), .halve(ctrl.halve), .sat(ctrl.sat),
      .en(!ctrl.useMask || maskWord[i]),
      .res(wideRes[16*i +: 16])
    );
  end

  always_comb begin
    if (ctrl.illegal)   nextRes = '0;
    else if (ctrl.wide) nextRes = wideRes;
    else                nextRes = narrowRes;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
    end else begin
      outValid <= inValid;
    end
    if (inValid) begin
      outResult  <= nextRes;
      outIllegal <= ctrl.illegal;
    end
  end

endmodule

// File: rtl/lane_addsub_unit.sv
module lane_addsub_unit
  import lane_addsub_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [IDX_W-1:0]  rdIdx,
  input  logic [IDX_W-1:0]  rs1Idx,
  input  logic [IDX_W-1:0]  rs2Idx,
  input  logic [1:0]        opSel,
  input  logic [1:0]        mode,
  input  logic [WORD_W-1:0] srcA,
  input  logic [WORD_W-1:0] srcB,
  input  logic [WORD_W-1:0] oldDest,
  input  logic [WORD_W-1:0] predWord,
  output logic              outValid,
  output logic [WORD_W-1:0] outResult,
  output logic              outIllegal
);

  ctrl_t ctrl;

  addsub_ctrl #(.IDX_W(IDX_W)) uCtrl (
    .rdIdx(rdIdx), .rs1Idx(rs1Idx), .rs2Idx(rs2Idx),
    .opSel(opSel), .mode(mode), .ctrl(ctrl)
  );

  addsub_datapath #(.WORD_W(WORD_W)) uDp (
    .clk(clk), .rst(rst), .inValid(inValid), .ctrl(ctrl),
    .srcA(srcA), .srcB(srcB), .oldDest(oldDest), .predWord(predWord),
    .outValid(outValid), .outResult(outResult), .outIllegal(outIllegal)
  );

endmodule

// File: rtl/lane_addsub_checker.sv
module lane_addsub_checker #(
  parameter int WORD_W = 32,
  parameter int IDX_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic [IDX_W-1:0]  rdIdx,
  input logic [IDX_W-1:0]  rs1Idx,
  input logic [IDX_W-1:0]  rs2Idx,
  input logic [1:0]        opSel,
  input logic [1:0]        mode,
  input logic [WORD_W-1:0] srcA,
  input logic [WORD_W-1:0] srcB,
  input logic [WORD_W-1:0] oldDest,
  input logic [WORD_W-1:0] predWord,
  input logic              outValid,
  input logic [WORD_W-1:0] outResult,
  input logic              outIllegal
);

  logic allS8, allS16;
  assign allS8  = (rdIdx >= 2 && rdIdx <= 7) && (rs1Idx >= 2 && rs1Idx <= 7) &&
                  (rs2Idx >= 2 && rs2Idx <= 7);
  assign allS16 = (rdIdx >= 16 && rdIdx <= 23) && (rs1Idx >= 16 && rs1Idx <= 23) &&
                  (rs2Idx >= 16 && rs2Idx <= 23);

  AST_VALID_NEXT_EDGE: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid); // R9
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid); // R9
  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (rst)
    (outValid && outIllegal) |-> (outResult == '0)); // R3
  AST_PRED_REG_REJECT: assert property (@(posedge clk) disable iff (rst)
    (inValid && (rdIdx == 1 || rs1Idx == 1 || rs2Idx == 1)) |=> outIllegal); // R3
  AST_S8_ACCEPTED: assert property (@(posedge clk) disable iff (rst)
    (inValid && allS8) |=> !outIllegal); // R1
  AST_S16_ACCEPTED: assert property (@(posedge clk) disable iff (rst)
    (inValid && allS16) |=> !outIllegal); // R2
  AST_ADD_ZERO_IDENT: assert property (@(posedge clk) disable iff (rst)
    (inValid && mode == 2'b00 && opSel == 2'b00 && srcB == '0)
      |=> (outIllegal || outResult == $past(srcA))); // R4
  AST_MASK_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
    (inValid && mode == 2'b10 && predWord[3:0] == 4'h0)
      |=> (outIllegal || outResult == $past(oldDest))); // R7
  AST_INVMASK_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
    (inValid && mode == 2'b11 && predWord[3:0] == 4'hF)
      |=> (outIllegal || outResult == $past(oldDest))); // R8

endmodule

bind lane_addsub_unit lane_addsub_checker #(.WORD_W(WORD_W), .IDX_W(IDX_W)) uChk (.*);

// File: tb/lane_addsub_unit_test.sv
module lane_addsub_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [4:0]  rdIdx = '0, rs1Idx = '0, rs2Idx = '0;
  logic [1:0]  opSel = '0, mode = '0;
  logic [31:0] srcA = '0, srcB = '0, oldDest = '0, predWord = '0;
  logic        outValid, outIllegal;
  logic [31:0] outResult;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk; // 125 MHz

  lane_addsub_unit uut (.*);

  logic [7:0]  v8  [16] = '{8'h00, 8'h01, 8'h02, 8'h3f, 8'h40, 8'h7e, 8'h7f, 8'h80,
                            8'h81, 8'hbf, 8'hc0, 8'hfe, 8'hff, 8'h55, 8'haa, 8'h10};
  logic [15:0] v16 [16] = '{16'h0000, 16'h0001, 16'h0002, 16'h3fff, 16'h4000, 16'h7ffe,
                            16'h7fff, 16'h8000, 16'h8001, 16'hbfff, 16'hc000, 16'hfffe,
                            16'hffff, 16'h5555, 16'haaaa, 16'h0100};

  int bankLo [4] = '{2, 8, 16, 24};
  int bankHi [4] = '{7, 15, 23, 29};

  function automatic logic [31:0] model(input logic [31:0] a, b, old, pred,
                                        input logic [1:0] op, md,
                                        input bit wide, sgn);
    logic [31:0] res;
    int n, lanes;
    n = wide ? 16 : 8;
    lanes = 32 / n;
    res = '0;
    for (int l = 0; l < lanes; l++) begin
      int x, y, r, lo, hi;
      bit en;
      logic [15:0] fa, fb;
      if (wide) begin
        fa = a[l*16 +: 16]; fb = b[l*16 +: 16];
        x = sgn ? int'($signed(fa)) : int'(fa);
        y = sgn ? int'($signed(fb)) : int'(fb);
      end else begin
        fa = {8'h00, a[l*8 +: 8]}; fb = {8'h00, b[l*8 +: 8]};
        x = sgn ? int'($signed(fa[7:0])) : int'(fa);
        y = sgn ? int'($signed(fb[7:0])) : int'(fb);
      end
      r = op[0] ? x - y : x + y;
      if (op[1]) r = r >>> 1;
      else if (md == 2'b01) begin
        lo = sgn ? -(1 << (n - 1)) : 0;
        hi = sgn ? (1 << (n - 1)) - 1 : (1 << n) - 1;
        if (r < lo) r = lo;
        if (r > hi) r = hi;
      end
      en = md[1] ? (md[0] ? !pred[l] : pred[l]) : 1'b1;
      if (wide) res[l*16 +: 16] = en ? r[15:0] : old[l*16 +: 16];
      else      res[l*8 +: 8]   = en ? r[7:0]  : old[l*8 +: 8];
    end
    return res;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", checks, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(outValid === 1'b0, "R9 reset", {31'd0, outValid}, 32'd0);
    rst = 1'b0;

    // Main sweep: all four banks, ops, modes, edge-value pairs
    for (int bk = 0; bk < 4; bk++) begin
      for (int op = 0; op < 4; op++) begin
        for (int md = 0; md < 4; md++) begin
          for (int ia = 0; ia < 16; ia++) begin
            for (int ib = 0; ib < 16; ib++) begin
              logic [31:0] exp;
              bit wide, sgn;
              string tag;
              wide = (bk >= 2);
              sgn  = (bk == 0) || (bk == 2);
              @(negedge clk);
              rdIdx  = 5'((ia & 1) ? bankHi[bk] : bankLo[bk]);
              rs1Idx = 5'((ib & 1) ? bankHi[bk] : bankLo[bk]);
              rs2Idx = 5'(((ia ^ ib) & 2) ? bankHi[bk] : bankLo[bk] + 1);
              opSel  = 2'(op);
              mode   = 2'(md);
              for (int j = 0; j < 4; j++) begin
                if (wide) begin
                  if (j < 2) begin
                    srcA[j*16 +: 16] = v16[(ia + j*3) & 15];
                    srcB[j*16 +: 16] = v16[(ib + j*7) & 15];
                  end
                end else begin
                  srcA[j*8 +: 8] = v8[(ia + j*3) & 15];
                  srcB[j*8 +: 8] = v8[(ib + j*7) & 15];
                end
              end
              oldDest  = 32'hA5C3_5A3C ^ {ib[7:0], ia[7:0], ib[7:0], ia[7:0]};
              predWord = {24'hC3A55A, ib[3:0], ia[3:0]};
              inValid  = 1'b1;
              exp = model(srcA, srcB, oldDest, predWord, opSel, mode, wide, sgn);
              if (op >= 2)      tag = "R6 halving";
              else if (md == 1) tag = "R5 saturate";
              else if (md == 2) tag = "R7 mask";
              else if (md == 3) tag = "R8 inverted mask";
              else              tag = "R4 plain";
              tag = {tag, wide ? " R2 wide" : " R1 narrow"};
              @(negedge clk);
              check(outValid === 1'b1 && outIllegal === 1'b0 && outResult === exp,
                    tag, outResult, exp);
            end
          end
        end
      end
    end

    // R9: valid drops after an idle edge
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    check(outValid === 1'b0, "R9 idle", {31'd0, outValid}, 32'd0);

    // R3: reserved and cross-bank index triples
    begin
      int trip [6][3] = '{'{0, 2, 3}, '{2, 1, 3}, '{16, 17, 30}, '{31, 24, 25},
                          '{3, 9, 4}, '{16, 24, 17}};
      for (int t = 0; t < 6; t++) begin
        @(negedge clk);
        rdIdx = 5'(trip[t][0]); rs1Idx = 5'(trip[t][1]); rs2Idx = 5'(trip[t][2]);
        opSel = 2'b00; mode = 2'b00;
        srcA = 32'h1234_5678; srcB = 32'h0101_0101; oldDest = 32'hFFFF_FFFF;
        inValid = 1'b1;
        @(negedge clk);
        check(outValid === 1'b1 && outIllegal === 1'b1 && outResult === 32'd0,
              "R3 illegal", outResult, 32'd0);
      end
    end

    // R9: synchronous reset clears valid
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(outValid === 1'b0, "R9 sync reset", {31'd0, outValid}, 32'd0);
    inValid = 1'b0;
    rst = 1'b0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule